// File: doc/BRIEF.md
# Two-Bank GPIO Output and Configuration Register File

This block is the register-mapped core of a general-purpose I/O controller for up to 128 pads. The pads are grouped into banks of 64. Pad n sits in bank n/64 at bit n%64. Each bank has three registers:

- a register that returns the sampled pad levels;
- a write-one-to-set register for the output latch;
- a write-one-to-clear register for the output latch.

Software never writes the output latch as a whole word. Every change goes through a set strobe or a clear strobe, so two agents that each own different pins cannot overwrite each other's bits.

Each pad also has its own configuration word with four fields: drive enable, polarity inversion, open-drain drive, and a function-select field. While the function-select field is nonzero, an alternate on-chip function owns the pad. In that state the pad follows the alternate output and enable inputs, and set and clear writes cannot change that pad's latch bit. A read-only identity register reports the pad count and the first interrupt vector number. Glitch filtering and interrupt generation are separate blocks that attach to the sampled input path.

Top module: `gpio_bank_regfile`

## Requirements
- R1: Bank b places its registers at base b*0x1400: pad levels at offset 0x0, set at 0x8 and clear at 0x10. The configuration word of pad n is at 0x400 + 8*n. The identity register is at 0x90. A read (reg_rd high for one cycle) is answered on the next cycle with reg_rvalid high and the data on reg_rdata. Unmapped or misaligned addresses read as zero.
- R2: A write to a bank's set register raises every latch bit whose write-data bit is 1. Bits written with 0 keep their value.
- R3: A write to a bank's clear register lowers every latch bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: Reading the set register returns the bank's output latch. Reading the clear register returns zero.
- R5: For a pad in GPIO mode with open-drain drive off, pad_oe equals the drive-enable bit (bit 0) and pad_out equals the latch bit XOR the inversion bit (bit 1).
- R6: With open-drain drive on (bit 12), the pad's pad_out is always 0. pad_oe is 1 only when the drive-enable bit is set and the latch bit XOR the inversion bit is 0.
- R7: The pad-level register returns pad_in XOR each pad's inversion bit. The value comes through one sampling register, so a read issued at least one cycle after a pad change sees the change.
- R8: While a pad's function-select field (bits 25:16) is nonzero, its pad_out and pad_oe follow alt_out and alt_oe. When the field returns to zero, the pad goes back to its GPIO drive.
- R9: Set and clear writes leave the latch bits of pads with a nonzero function-select field unchanged. The other bits in the same write take effect.
- R10: A configuration word reads back bits 0, 1, 12 and 25:16 as written. All other bits read as zero.
- R11: The identity register reads the pad count in bits 7:0 and VEC_BASE in bits 15:8. All other bits are zero. Writes to it have no effect.
- R12: Reset clears all output latches and configuration words. Every pad then has pad_oe = 0 and pad_out = 0.
- R13: Pad n maps to bank n/64 at bit n%64. For example, pad 70 is bit 6 of the bank-1 set register at 0x1408.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | High one cycle after reg_rd |
| pad_in | input | NUM_PINS | Pad input levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| alt_out | input | NUM_PINS | Output values from the alternate function |
| alt_oe | input | NUM_PINS | Output enables from the alternate function |

## Verification
The failures that matter most are a wrong latch bit, a lost inversion bit, and a lock flag that does not hold. Each one reaches pad_out or pad_oe in the same cycle the faulty state is written. The bench checks these pads right after each write. It also reads the set register back, which exposes a latch fault one cycle after the read strobe.

Address-decode faults show up as data in the wrong bank or in the wrong register. The bench therefore drives distinct patterns into the two banks, addresses pad 70 through bank 1, and reads unmapped, misaligned and read-only addresses.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

  localparam int BANK_W      = 64;
  localparam int BANK_STRIDE = 'h1400;
  localparam int OFF_LEVEL   = 'h0;
  localparam int OFF_SET     = 'h8;
  localparam int OFF_CLR     = 'h10;
  localparam int OFF_IDENT   = 'h90;
  localparam int CFG_BASE    = 'h400;
  localparam int CFG_STRIDE  = 8;

  localparam int BIT_DRIVE   = 0;
  localparam int BIT_INVERT  = 1;
  localparam int BIT_OPEN_DR = 12;
  localparam int FSEL_LSB    = 16;
  localparam int FSEL_W      = 10;

  typedef struct packed {
    logic [FSEL_W-1:0] fsel;
    logic              open_dr;
    logic              invert;
    logic              drive;
  } pin_cfg_t;

  function automatic logic [63:0] cfg_to_word(pin_cfg_t c);
    logic [63:0] w;
    w = '0;
    w[BIT_DRIVE]                  = c.drive;
    w[BIT_INVERT]                 = c.invert;
    w[BIT_OPEN_DR]                = c.open_dr;
    w[FSEL_LSB +: FSEL_W]         = c.fsel;
    return w;
  endfunction

endpackage

// File: rtl/gpio_cfg_file.sv
module gpio_cfg_file
  import gpio_regs_pkg::*;
#(
  parameter int NUM_PINS = 128,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  pin_cfg_t            wr_cfg,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [63:0]         rd_word,
  output logic [NUM_PINS-1:0] drive_vec,
  output logic [NUM_PINS-1:0] invert_vec,
  output logic [NUM_PINS-1:0] open_dr_vec,
  output logic [NUM_PINS-1:0] lock_vec
);

  pin_cfg_t cfg_q [NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic load;

    always_comb load = wr_en && (wr_idx == IDX_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cfg_q[p] <= '0;
      else if (load) cfg_q[p] <= wr_cfg;
    end

    always_comb begin
      drive_vec[p]   = cfg_q[p].drive;
      invert_vec[p]  = cfg_q[p].invert;
      open_dr_vec[p] = cfg_q[p].open_dr;
      lock_vec[p]    = |cfg_q[p].fsel;
    end
  end

  always_comb rd_word = cfg_to_word(cfg_q[rd_idx]);

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] lock,
  output logic [W-1:0] q
);

  logic [W-1:0] mask;
  logic [W-1:0] q_next;
  logic         load;

  always_comb begin
    mask   = wdata & ~lock;
    load   = set_stb | clr_stb;
    q_next = q;
    if (set_stb)      q_next = q | mask;
    else if (clr_stb) q_next = q & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= q_next;
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((q & $past(wdata & ~lock)) == $past(wdata & ~lock))); // R2
  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((q & $past(wdata & ~lock)) == '0)); // R3
  AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb || clr_stb) |=> (((q ^ $past(q)) & ~$past(wdata & ~lock)) == '0)); // R9

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int N = 128
) (
  input  logic [N-1:0] latch,
  input  logic [N-1:0] drive,
  input  logic [N-1:0] invert,
  input  logic [N-1:0] open_dr,
  input  logic [N-1:0] lock,
  input  logic [N-1:0] alt_out,
  input  logic [N-1:0] alt_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe
);

  for (genvar i = 0; i < N; i++) begin : g_pad
    logic level;
    always_comb begin
      level = latch[i] ^ invert[i];
      if (lock[i]) begin
        pad_out[i] = alt_out[i];
        pad_oe[i]  = alt_oe[i];
      end else if (open_dr[i]) begin
        pad_out[i] = 1'b0;
        pad_oe[i]  = drive[i] & ~level;
      end else begin
        pad_out[i] = level;
        pad_oe[i]  = drive[i];
      end
    end
  end

endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
  import gpio_regs_pkg::*;
#(
  parameter int NUM_PINS = 128,
  parameter int VEC_BASE = 48,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [63:0]         reg_wdata,
  output logic [63:0]         reg_rdata,
  output logic                reg_rvalid,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic [NUM_PINS-1:0] alt_out,
  input  logic [NUM_PINS-1:0] alt_oe
);

  localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int TOT_W     = NUM_BANKS * BANK_W;
  localparam int IDX_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int CFG_SPAN  = CFG_STRIDE * NUM_PINS;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // address decode
  logic [NUM_BANKS-1:0] lvl_hit, set_hit, clr_hit;
  logic                 ident_hit, cfg_hit;
  logic [ADDR_W-1:0]    cfg_off;
  logic [IDX_W-1:0]     cfg_idx;

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      lvl_hit[b] = (reg_addr == ADDR_W'(b * BANK_STRIDE + OFF_LEVEL));
      set_hit[b] = (reg_addr == ADDR_W'(b * BANK_STRIDE + OFF_SET));
      clr_hit[b] = (reg_addr == ADDR_W'(b * BANK_STRIDE + OFF_CLR));
    end
    ident_hit = (reg_addr == ADDR_W'(OFF_IDENT));
    cfg_off   = reg_addr - ADDR_W'(CFG_BASE);
    cfg_hit   = (reg_addr >= ADDR_W'(CFG_BASE)) && (cfg_off < ADDR_W'(CFG_SPAN))
                && (cfg_off[2:0] == 3'b000);
    cfg_idx   = cfg_off[IDX_W+2:3];
  end

  // configuration words
  pin_cfg_t            cfg_wr;
  logic [63:0]         cfg_rd_word;
  logic [NUM_PINS-1:0] drive_vec, invert_vec, open_dr_vec, lock_vec;

  always_comb begin
    cfg_wr.drive   = reg_wdata[BIT_DRIVE];
    cfg_wr.invert  = reg_wdata[BIT_INVERT];
    cfg_wr.open_dr = reg_wdata[BIT_OPEN_DR];
    cfg_wr.fsel    = reg_wdata[FSEL_LSB +: FSEL_W];
  end

  gpio_cfg_file #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_ni),
    .wr_en       (reg_wr && cfg_hit),
    .wr_idx      (cfg_idx),
    .wr_cfg      (cfg_wr),
    .rd_idx      (cfg_idx),
    .rd_word     (cfg_rd_word),
    .drive_vec   (drive_vec),
    .invert_vec  (invert_vec),
    .open_dr_vec (open_dr_vec),
    .lock_vec    (lock_vec)
  );

  // output latches, one per bank
  logic [TOT_W-1:0] latch_all;
  logic [TOT_W-1:0] lock_all;

  assign lock_all = TOT_W'(lock_vec);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_out_latch #(.W(BANK_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_ni),
      .set_stb (reg_wr && set_hit[b]),
      .clr_stb (reg_wr && clr_hit[b]),
      .wdata   (reg_wdata),
      .lock    (lock_all[b*BANK_W +: BANK_W]),
      .q       (latch_all[b*BANK_W +: BANK_W])
    );
  end

  // pad drive
  gpio_pad_drive #(.N(NUM_PINS)) u_pads (
    .latch   (latch_all[NUM_PINS-1:0]),
    .drive   (drive_vec),
    .invert  (invert_vec),
    .open_dr (open_dr_vec),
    .lock    (lock_vec),
    .alt_out (alt_out),
    .alt_oe  (alt_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  // sampled input levels, polarity corrected
  logic [TOT_W-1:0] level_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= TOT_W'(pad_in ^ invert_vec);
  end

  // read path
  logic [63:0] rdata_next;

  always_comb begin
    rdata_next = '0;
    if (ident_hit) rdata_next = (64'(VEC_BASE & 'hff) << 8) | 64'(NUM_PINS & 'hff);
    if (cfg_hit)   rdata_next = cfg_rd_word;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (lvl_hit[b]) rdata_next = level_q[b*BANK_W +: BANK_W];
      if (set_hit[b]) rdata_next = latch_all[b*BANK_W +: BANK_W];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rdata_next;
    end
  end

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_ni)
    reg_rd |=> reg_rvalid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_ni)
    !reg_rd |=> !reg_rvalid); // R1
  AST_OPEN_DRAIN_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |-> ((pad_out & open_dr_vec & ~lock_vec) == '0)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_ni |-> (pad_oe == '0)); // R12

endmodule

// File: tb/tb_gpio_bank_regfile.sv
module tb_gpio_bank_regfile;

  localparam int NP = 128;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [15:0]   reg_addr;
  logic          reg_wr, reg_rd;
  logic [63:0]   reg_wdata, reg_rdata;
  logic          reg_rvalid;
  logic [NP-1:0] pad_in, pad_out, pad_oe, alt_out, alt_oe;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gpio_bank_regfile #(.NUM_PINS(NP), .VEC_BASE(48), .ADDR_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R1 rvalid", 64'(reg_rvalid), 64'd1);
    d = reg_rdata;
  endtask

  function automatic logic [15:0] cfg_a(input int n);
    return 16'(16'h400 + 8 * n);
  endfunction

  task automatic t_reset();
    logic [63:0] d;
    chk("R12 pad_oe lo", pad_oe[63:0], 64'd0);
    chk("R12 pad_oe hi", pad_oe[127:64], 64'd0);
    chk("R12 pad_out", pad_out[63:0] | pad_out[127:64], 64'd0);
    rd(16'h0008, d); chk("R12 latch bank0", d, 64'd0);
    rd(cfg_a(5), d); chk("R12 cfg pad5", d, 64'd0);
  endtask

  task automatic t_ident();
    logic [63:0] d;
    rd(16'h0090, d); chk("R11 ident", d, 64'h3080);
    wr(16'h0090, '1);
    rd(16'h0090, d); chk("R11 ident after write", d, 64'h3080);
    rd(16'h0200, d); chk("R1 unmapped", d, 64'd0);
    rd(16'h0404, d); chk("R1 misaligned", d, 64'd0);
  endtask

  task automatic t_input();
    logic [63:0] d;
    wr(cfg_a(3), 64'h2);
    pad_in = {64'h0123_4567_89AB_CDEF, 64'hA5A5_0000_1234_5678};
    rd(16'h0000, d); chk("R7 bank0 levels", d, 64'hA5A5_0000_1234_5670);
    rd(16'h1400, d); chk("R7 bank1 levels", d, 64'h0123_4567_89AB_CDEF);
    wr(cfg_a(3), 64'h0);
    rd(16'h0000, d); chk("R7 inversion removed", d, 64'hA5A5_0000_1234_5678);
  endtask

  task automatic t_setclr();
    logic [63:0] d;
    wr(16'h0008, 64'hF0F0);
    rd(16'h0008, d); chk("R2 set", d, 64'hF0F0);
    wr(16'h0008, 64'h0F00);
    rd(16'h0008, d); chk("R2 set keeps zeros", d, 64'hFFF0);
    wr(16'h0010, 64'h00F0);
    rd(16'h0008, d); chk("R3 clear", d, 64'hFF00);
    rd(16'h0010, d); chk("R4 clear reads zero", d, 64'd0);
    wr(16'h1408, 64'h40);
    rd(16'h1408, d); chk("R13 bank1 latch", d, 64'h40);
    rd(16'h0008, d); chk("R13 bank0 untouched", d, 64'hFF00);
  endtask

  task automatic t_pushpull();
    wr(cfg_a(8), 64'h1);
    chk("R5 pad8 oe", 64'(pad_oe[8]), 64'd1);
    chk("R5 pad8 out", 64'(pad_out[8]), 64'd1);
    wr(cfg_a(8), 64'h3);
    chk("R5 pad8 inverted", 64'(pad_out[8]), 64'd0);
    wr(cfg_a(4), 64'h1);
    chk("R5 pad4 low", {pad_oe[4], pad_out[4]}, 64'b10);
    wr(cfg_a(70), 64'h1);
    chk("R13 pad70 out", {pad_oe[70], pad_out[70]}, 64'b11);
  endtask

  task automatic t_opendrain();
    wr(cfg_a(9), 64'h1001);
    chk("R6 od high released", {pad_oe[9], pad_out[9]}, 64'b00);
    wr(16'h0010, 64'h200);
    chk("R6 od low driven", {pad_oe[9], pad_out[9]}, 64'b10);
    wr(cfg_a(10), 64'h1003);
    chk("R6 od inverted drives", {pad_oe[10], pad_out[10]}, 64'b10);
  endtask

  task automatic t_cfgread();
    logic [63:0] d;
    wr(cfg_a(20), '1);
    rd(cfg_a(20), d); chk("R10 cfg fields", d, 64'h03FF_1003);
    wr(cfg_a(20), 64'h0);
    rd(cfg_a(20), d); chk("R10 cfg cleared", d, 64'd0);
  endtask

  task automatic t_lock();
    logic [63:0] d;
    alt_out[30] = 1'b1; alt_oe[30] = 1'b1;
    wr(cfg_a(30), 64'h5_0001);
    chk("R8 alt drives", {pad_oe[30], pad_out[30]}, 64'b11);
    alt_out[30] = 1'b0;
    #1 chk("R8 alt follows", {pad_oe[30], pad_out[30]}, 64'b10);
    wr(16'h0008, 64'hC000_0000);
    rd(16'h0008, d); chk("R9 locked bit kept", d, 64'h8000_FD00);
    wr(cfg_a(30), 64'h1);
    alt_oe[30] = 1'b0;
    #1 chk("R8 released to gpio", {pad_oe[30], pad_out[30]}, 64'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    pad_in = '0; alt_out = '0; alt_oe = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ident();
    t_input();
    t_setclr();
    t_pushpull();
    t_opendrain();
    t_cfgread();
    t_lock();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule